// File: doc/BRIEF.md
# Prioritized Interrupt Source Arbiter

This block collects seven single-cycle event pulses from a serial bus controller and folds them into one interrupt request. Each event sets a sticky bit in a status register. A per-source enable register decides which pending bits may request an interrupt. A fixed-priority arbiter picks the most urgent pending and enabled source and registers its code into a source-code register. The interrupt output is high exactly when that code is non-zero.

Software learns the active event by reading the source-code register. For most sources this read also acknowledges the event by clearing its status bit. The arbiter then presents the next pending source one clock later. Three ready flags (access ready, receive ready, transmit ready) report conditions rather than one-off events. A source-code read leaves them set, and software must clear them by writing one to their status bit.

The register port is a plain single-cycle read/write strobe interface with a two-bit address. Address 0 is status: bits 6..0 hold the flags, reads return them, and writing 1 to a bit clears it. Address 1 is enable: bits 6..0 are read/write. Address 2 is the source code: bits 2..0, read-only, and reading clears the reported flag. Address 3 reads as zero. Read data follows the address combinationally and shows the state before the access takes effect.

Top module: `irq_src_arbiter`

## Requirements
- R1: After reset the status flags, the enables, the source code and `irq_o` are all zero.
- R2: A pulse on `evt_i[k]` sets status bit k at the next clock edge. The bit then stays set without further pulses until it is cleared. Bit meanings: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: A pending source whose enable bit is 0 never raises `irq_o`. The source code is 0 when no flag is both set and enabled, and `irq_o` is low whenever the source code is 0.
- R4: The source code is k+1 for the lowest bit index k that is both set and enabled, so bit 0 (code 1) has the highest priority and bit 6 (code 7) the lowest.
- R5: The source code and `irq_o` follow a change of flags or enables one clock later. After an event pulse they respond at the second clock edge.
- R6: A read of address 2 returns the code from before the read. It clears status bit code-1 at that clock edge when that bit is 0, 1, 5 or 6.
- R7: A read of address 2 never clears status bits 2, 3 or 4. Writing 1 to them at address 0 does clear them.
- R8: Writing 0 to a status bit leaves that bit unchanged.
- R9: If an event pulse arrives in the same cycle as a clear of its bit, by write-one or by source read, the bit ends up set.
- R10: After a source read clears the reported flag, the next pending enabled source of highest priority is presented, and `irq_o` stays high while one remains.
- R11: The enable register reads back what was written. The status register shows set flags whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle event pulses, bit index as in R2 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 enable, 2 source code) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register, state before the access |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check several properties against the flags and enables. The interrupt output follows the previous cycle's pending-and-enabled set. The registered code equals the lowest-index winner. An event always leaves its bit set even under a simultaneous clear. A source read clears only event-type flags and never the three ready flags. A zero write never drops a bit. Only the bench's scenarios can show the end-to-end sequences as software sees them. These are the whole drain order through successive reads, the value a read returns before its own side effect, the exact cycle in which the code moves after an enable write, masking by enables, and enable read-back.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned NUM_SRC = 7;
    localparam int unsigned CODE_W  = $clog2(NUM_SRC + 1);
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 2;

    // flags that survive a source-code read (access, receive, transmit ready)
    localparam logic [NUM_SRC-1:0] KEEP_ON_READ = 7'b001_1100;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SOURCE = 2'd2;

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
        logic [NUM_SRC-1:0] en;
        logic [CODE_W-1:0]  src;
        logic               irq;
    } arb_state_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_arb_pkg::*;
#(
    parameter int unsigned P_NUM_SRC = NUM_SRC,
    parameter int unsigned P_CODE_W  = CODE_W,
    parameter int unsigned P_DATA_W  = DATA_W,
    parameter int unsigned P_ADDR_W  = ADDR_W
) (
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [P_ADDR_W-1:0]  addr_i,
    input  logic [P_DATA_W-1:0]  wdata_i,
    input  logic [P_NUM_SRC-1:0] flags_i,
    input  logic [P_NUM_SRC-1:0] en_i,
    input  logic [P_CODE_W-1:0]  src_i,
    output logic [P_NUM_SRC-1:0] w1c_o,
    output logic                 en_wr_o,
    output logic [P_NUM_SRC-1:0] en_val_o,
    output logic                 src_rd_o,
    output logic [P_DATA_W-1:0]  rdata_o
);

    always_comb begin
        w1c_o    = '0;
        en_wr_o  = 1'b0;
        en_val_o = wdata_i[P_NUM_SRC-1:0];
        src_rd_o = rd_i && (addr_i == ADDR_SOURCE);
        if (wr_i && (addr_i == ADDR_STATUS)) begin
            w1c_o = wdata_i[P_NUM_SRC-1:0];
        end
        if (wr_i && (addr_i == ADDR_ENABLE)) begin
            en_wr_o = 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_STATUS: rdata_o[P_NUM_SRC-1:0] = flags_i;
            ADDR_ENABLE: rdata_o[P_NUM_SRC-1:0] = en_i;
            ADDR_SOURCE: rdata_o[P_CODE_W-1:0]  = src_i;
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_flag_next.sv
module irq_flag_next
    import irq_arb_pkg::*;
#(
    parameter int unsigned          P_NUM_SRC = NUM_SRC,
    parameter int unsigned          P_CODE_W  = CODE_W,
    parameter logic [P_NUM_SRC-1:0] P_KEEP    = KEEP_ON_READ
) (
    input  logic [P_NUM_SRC-1:0] flags_i,
    input  logic [P_NUM_SRC-1:0] evt_i,
    input  logic [P_NUM_SRC-1:0] w1c_i,
    input  logic [P_CODE_W-1:0]  src_i,
    input  logic                 src_rd_i,
    output logic [P_NUM_SRC-1:0] flags_d_o
);

    for (genvar k = 0; k < P_NUM_SRC; k++) begin : g_bit
        logic rd_clr;
        if (P_KEEP[k]) begin : g_keep
            assign rd_clr = 1'b0;
        end else begin : g_ack
            assign rd_clr = src_rd_i && (src_i == P_CODE_W'(k + 1));
        end
        // set has priority over every clear
        assign flags_d_o[k] = evt_i[k] | (flags_i[k] & ~w1c_i[k] & ~rd_clr);
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_arb_pkg::*;
#(
    parameter int unsigned P_NUM_SRC = NUM_SRC,
    parameter int unsigned P_CODE_W  = CODE_W
) (
    input  logic [P_NUM_SRC-1:0] req_i,
    output logic [P_CODE_W-1:0]  code_o
);

    always_comb begin
        code_o = '0;
        for (int k = P_NUM_SRC - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                code_o = P_CODE_W'(k + 1);
            end
        end
    end

endmodule

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter
    import irq_arb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    arb_state_t state_d, state_q;

    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] en_q;
    logic [CODE_W-1:0]  src_q;

    logic [NUM_SRC-1:0] w1c;
    logic               en_wr;
    logic [NUM_SRC-1:0] en_val;
    logic               src_rd;
    logic [NUM_SRC-1:0] flags_nxt;
    logic [CODE_W-1:0]  win_code;

    assign flags_q = state_q.flags;
    assign en_q    = state_q.en;
    assign src_q   = state_q.src;

    irq_reg_decode u_decode (
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .flags_i  (flags_q),
        .en_i     (en_q),
        .src_i    (src_q),
        .w1c_o    (w1c),
        .en_wr_o  (en_wr),
        .en_val_o (en_val),
        .src_rd_o (src_rd),
        .rdata_o  (reg_rdata_o)
    );

    irq_flag_next u_flags (
        .flags_i   (flags_q),
        .evt_i     (evt_i),
        .w1c_i     (w1c),
        .src_i     (src_q),
        .src_rd_i  (src_rd),
        .flags_d_o (flags_nxt)
    );

    irq_prio_enc u_prio (
        .req_i  (flags_q & en_q),
        .code_o (win_code)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flags_nxt;
        if (en_wr) begin
            state_d.en = en_val;
        end
        state_d.src = win_code;
        state_d.irq = (win_code != '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;

endmodule

// File: rtl/irq_src_arbiter_chk.sv
module irq_src_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               wr_i,
    input logic               rd_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [NUM_SRC-1:0] flags_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic [CODE_W-1:0]  src_i,
    input logic               irq_i
);

    logic               src_rd;
    logic               stat_wr;
    logic [NUM_SRC-1:0] pend;
    logic [CODE_W-1:0]  ref_code;

    assign src_rd  = rd_i && (addr_i == ADDR_SOURCE);
    assign stat_wr = wr_i && (addr_i == ADDR_STATUS);
    assign pend    = flags_i & en_i;

    // independent reference: ascending scan, first hit wins
    always_comb begin
        logic found;
        found    = 1'b0;
        ref_code = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (!found && pend[k]) begin
                found    = 1'b1;
                ref_code = CODE_W'(k + 1);
            end
        end
    end

    // R3 R5
    irq_follows_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (irq_i == $past(|pend)));

    // R4
    code_is_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (src_i == $past(ref_code)));

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        // R2 R9
        evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[k] |=> flags_i[k]);

        // R8
        zero_write_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_wr && !wdata_i[k] && flags_i[k] && !src_rd) |=> flags_i[k]);

        if (KEEP_ON_READ[k]) begin : g_keep
            // R7
            ready_survives_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (src_rd && flags_i[k] && !(stat_wr && wdata_i[k])) |=> flags_i[k]);
        end else begin : g_ack
            // R6
            read_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (src_rd && (src_i == CODE_W'(k + 1)) && !evt_i[k]) |=> !flags_i[k]);
        end
    end

endmodule

bind irq_src_arbiter irq_src_arbiter_chk chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flags_q),
    .en_i    (en_q),
    .src_i   (src_q),
    .irq_i   (irq_o)
);

// File: tb/irq_src_arbiter_tb_top.sv
module irq_src_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_src_arbiter dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .evt_i       (evt),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [6:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(2'd0, d); check("R1 status", d, 0);
        rd_reg(2'd1, d); check("R1 enable", d, 0);
        rd_reg(2'd2, d); check("R1 code", d, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_mask_then_enable();
        logic [7:0] d;
        pulse(7'h01);
        settle();
        rd_reg(2'd0, d); check("R2 flag set", d, 8'h01);
        check("R3 masked irq", irq, 0);
        settle();
        rd_reg(2'd0, d); check("R2 sticky", d, 8'h01);
        rd_reg(2'd2, d); check("R3 masked code", d, 0);
        wr_reg(2'd1, 8'h7F);
        check("R5 irq one cycle late", irq, 0);
        settle();
        check("R5 irq after lag", irq, 1);
        rd_reg(2'd1, d); check("R11 enable readback", d, 8'h7F);
    endtask

    task automatic t_priority_drain();
        logic [7:0] d;
        pulse(7'h62);
        settle();
        rd_reg(2'd0, d); check("R2 several flags", d, 8'h63);
        rd_reg(2'd2, d); check("R4 R6 first code", d, 1);
        check("R10 irq held", irq, 1);
        settle();
        rd_reg(2'd2, d); check("R4 R10 second code", d, 2);
        settle();
        rd_reg(2'd2, d); check("R4 R10 third code", d, 6);
        settle();
        rd_reg(2'd2, d); check("R4 R10 fourth code", d, 7);
        settle();
        check("R3 irq drops at code 0", irq, 0);
        rd_reg(2'd0, d); check("R6 all acked", d, 0);
        rd_reg(2'd2, d); check("R3 code zero", d, 0);
    endtask

    task automatic t_ready_flags();
        logic [7:0] d;
        pulse(7'h1C);
        settle();
        rd_reg(2'd2, d); check("R4 ready code", d, 3);
        settle();
        rd_reg(2'd0, d); check("R7 read keeps ready", d, 8'h1C);
        rd_reg(2'd2, d); check("R7 code unchanged", d, 3);
        wr_reg(2'd0, 8'h04);
        settle();
        rd_reg(2'd0, d); check("R7 w1c clears", d, 8'h18);
        rd_reg(2'd2, d); check("R7 next ready code", d, 4);
        wr_reg(2'd0, 8'h00);
        settle();
        rd_reg(2'd0, d); check("R8 zero write", d, 8'h18);
        wr_reg(2'd0, 8'h18);
        settle();
        rd_reg(2'd0, d); check("R7 cleared all", d, 0);
        check("R3 irq low", irq, 0);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        pulse(7'h20);
        evt = 7'h20; wr = 1'b1; addr = 2'd0; wdata = 8'h20;
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
        rd_reg(2'd0, d); check("R9 set beats w1c", d, 8'h20);
        settle();
        evt = 7'h20; rd = 1'b1; addr = 2'd2;
        #1 d = rdata;
        @(negedge clk);
        evt = '0; rd = 1'b0;
        check("R6 read value", d, 6);
        rd_reg(2'd0, d); check("R9 set beats read", d, 8'h20);
        wr_reg(2'd0, 8'h20);
        settle();
        check("R9 cleared later", irq, 0);
    endtask

    task automatic t_enable_mask();
        logic [7:0] d;
        wr_reg(2'd1, 8'h40);
        pulse(7'h42);
        settle();
        rd_reg(2'd0, d); check("R11 status ignores enable", d, 8'h42);
        rd_reg(2'd2, d); check("R3 only enabled wins", d, 7);
        settle();
        check("R3 masked pending no irq", irq, 0);
        rd_reg(2'd2, d); check("R3 masked code", d, 0);
        wr_reg(2'd1, 8'h42);
        check("R5 enable lag", irq, 0);
        settle();
        rd_reg(2'd2, d); check("R4 unmasked code", d, 2);
        settle();
        check("R10 none left", irq, 0);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, d); check("R11 enable cleared", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_then_enable();
        t_priority_drain();
        t_ready_flags();
        t_set_wins();
        t_enable_mask();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog: actual 0 expected 1");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule